// File: doc/BRIEF.md
# Programmable Interval Counter Channel

A single 16-bit down-counting timer channel with six operating modes. A host writes a mode and then an initial count. The channel decrements on each cycle in which the count-enable input is high. The gate input either suspends counting or, in the triggerable modes, restarts it on a rising edge. The channel drives one output whose waveform depends on the mode: a level that rises at terminal count, a one-shot window, a rate pulse, a square wave, or a single strobe.

The live count and the output level are exposed directly. Latch and status capture logic outside the channel can sample them in any cycle. A decimal-counting flag is stored and reported only. Counting is always binary.

Mode codes are 3 bits. Codes 6 and 7 fold onto 2 and 3. A count of zero stands for 65536. Programming order is mode first, then count. Within one clock, a mode write takes priority over a count write. A count write takes priority over a gate trigger, and a gate trigger takes priority over a count step.

Top module: `interval_counter_channel`

## Requirements
- R1: After reset, out_o is 0, count_o is 0 and mode_o is 0. Until a mode is written, count writes and ticks are ignored: out_o stays 0 and count_o stays 0.
- R2: A loaded value of 0 acts as 65536. In mode 2 it gives a period of 65536 ticks. The counter passes through 0xFFFF on the first tick.
- R3: In modes 0, 1, 4 and 5 the counter does not stop after terminal count. It goes from 0 to 0xFFFF and keeps decrementing.
- R4: Mode 0: out_o is 0 after a count load. It becomes 1 on the tick that brings the count from 1 to 0, and it stays 1 until the next load or mode write.
- R5: Mode 1: a load only arms the channel, and nothing counts before a gate rising edge. Each rising edge reloads the count and sets out_o to 1. out_o returns to 0 on the tick that reaches terminal count.
- R6: Mode 2: out_o is 1 for one tick each time the count would reach 0. The counter then reloads the stored count, so pulses appear every N ticks.
- R7: Mode 3: out_o is high for the first (N+1)/2 ticks of each N-tick period and low for the rest. The counter steps by two per tick. With N=1, out_o stays high.
- R8: Modes 4 and 5: out_o is 0 except for exactly one tick, N ticks after the start. The start is the load in mode 4 and the gate rising edge in mode 5. No further pulse follows the wrap.
- R9: Gate handling by mode:
  - Modes 0, 2, 3 and 4 count only while gate is high.
  - Modes 1, 2, 3 and 5 restart from the stored count on a gate rising edge, whatever the gate level afterwards.
  - In modes 0 and 4 a gate rising edge does not restart the count.
- R10: A count written while the channel is armed has different effects by mode:
  - In modes 0 and 4 it restarts counting at once from the new value.
  - In modes 1, 2, 3 and 5 count_o is not changed. The new value is used at the next reload or gate trigger.
- R11: Mode codes 6 and 7 behave as modes 2 and 3, and mode_o reports the folded code. The decimal flag written with the mode appears on bcd_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count tick enable, one tick per high cycle |
| gate | input | 1 | Gate level, with rising-edge trigger |
| cfg_we | input | 1 | Mode write strobe |
| cfg_mode | input | 3 | Mode code 0..7 |
| cfg_bcd | input | 1 | Decimal flag, stored only |
| load_we | input | 1 | Count write strobe |
| load_val | input | W | Initial count, 0 means 65536 |
| count_o | output | W | Live counter value |
| out_o | output | 1 | Channel output level |
| mode_o | output | 3 | Folded active mode |
| bcd_o | output | 1 | Stored decimal flag |

## Verification
Every input takes effect at the next rising edge, and its effect is visible on the ports from that edge on. A mode write, a count load, a gate rising edge or a tick therefore shows on count_o and out_o exactly one clock later. A gate edge is seen in the clock where gate is first sampled high. The bench drives inputs on falling edges and samples on the following falling edge. Each tick is a single enabled cycle. This lets every expected value be computed from the tick index k since the start, as a modulo expression of k and the count N, with no timing slack.

// File: rtl/interval_counter_channel.sv
`timescale 1ns/1ps
module interval_counter_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         gate,
  input  logic         cfg_we,
  input  logic [2:0]   cfg_mode,
  input  logic         cfg_bcd,
  input  logic         load_we,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count_o,
  output logic         out_o,
  output logic [2:0]   mode_o,
  output logic         bcd_o
);

  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  logic [2:0]   mode_q;
  logic         bcd_q, prog_q, armed_q, run_q, fired_q, out_q, gate_q;
  logic [W-1:0] init_q, cnt_q;

  wire [2:0] mode_in   = (cfg_mode[2] & cfg_mode[1]) ? {1'b0, cfg_mode[1:0]} : cfg_mode;
  wire       trig_mode = (mode_q == 3'd1) || (mode_q == 3'd5);
  wire       periodic  = (mode_q == 3'd2) || (mode_q == 3'd3);
  wire       immediate = (mode_q == 3'd0) || (mode_q == 3'd4);
  wire       pulse_md  = (mode_q == 3'd2) || (mode_q == 3'd4) || (mode_q == 3'd5);
  wire       trig      = prog_q & armed_q & gate & ~gate_q & (trig_mode | periodic);
  wire       adv       = cnt_en & run_q & (gate | trig_mode);
  wire [W-1:0] half_lo = {init_q[W-1:1], 1'b0};

  function automatic logic [W-1:0] first_cnt(input logic [2:0] m, input logic [W-1:0] n);
    return (m == 3'd3) ? n + {{(W-1){1'b0}}, n[0]} : n;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0; bcd_q <= 1'b0; prog_q <= 1'b0; armed_q <= 1'b0;
      run_q <= 1'b0; fired_q <= 1'b0; out_q <= 1'b0; gate_q <= 1'b0;
      init_q <= '0; cnt_q <= '0;
    end else begin
      gate_q <= gate;
      if (cfg_we) begin
        mode_q  <= mode_in;
        bcd_q   <= cfg_bcd;
        prog_q  <= 1'b1;
        armed_q <= 1'b0;
        run_q   <= 1'b0;
        fired_q <= 1'b0;
        out_q   <= 1'b0;
      end else if (load_we && prog_q) begin
        init_q <= load_val;
        if (!armed_q || immediate) begin
          armed_q <= 1'b1;
          fired_q <= 1'b0;
          if (!trig_mode) begin
            cnt_q <= first_cnt(mode_q, load_val);
            run_q <= 1'b1;
            out_q <= (mode_q == 3'd3);
          end
        end
      end else if (trig) begin
        cnt_q   <= first_cnt(mode_q, init_q);
        run_q   <= 1'b1;
        fired_q <= 1'b0;
        out_q   <= (mode_q == 3'd1) || (mode_q == 3'd3);
      end else if (cnt_en) begin
        if (pulse_md) out_q <= 1'b0;
        if (adv) begin
          case (mode_q)
            3'd0: begin
              cnt_q <= cnt_q - ONE;
              if (cnt_q == ONE) out_q <= 1'b1;
            end
            3'd1: begin
              cnt_q <= cnt_q - ONE;
              if (cnt_q == ONE && !fired_q) begin out_q <= 1'b0; fired_q <= 1'b1; end
            end
            3'd2: begin
              if (cnt_q == ONE) begin cnt_q <= init_q; out_q <= 1'b1; end
              else cnt_q <= cnt_q - ONE;
            end
            3'd3: begin
              if (cnt_q == TWO) begin
                if (out_q && init_q != ONE) begin out_q <= 1'b0; cnt_q <= half_lo; end
                else begin out_q <= 1'b1; cnt_q <= first_cnt(3'd3, init_q); end
              end else cnt_q <= cnt_q - TWO;
            end
            default: begin
              cnt_q <= cnt_q - ONE;
              if (cnt_q == ONE && !fired_q) begin out_q <= 1'b1; fired_q <= 1'b1; end
            end
          endcase
        end
      end
    end
  end

  assign count_o = cnt_q;
  assign out_o   = out_q;
  assign mode_o  = mode_q;
  assign bcd_o   = bcd_q;

  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_q |-> !out_o);
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode_q == 3'd0 && cnt_q == '0 && !cfg_we && !load_we) |=> count_o == {W{1'b1}});
  assert_level_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd0 && out_q && !cfg_we && !load_we) |=> out_o);
  assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode_q == 3'd2 && cnt_q == ONE && !cfg_we && !load_we && !trig) |=> (out_o && count_o == $past(init_q)));
  assert_step_two_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode_q == 3'd3 && cnt_q != TWO && !cfg_we && !load_we && !trig) |=> count_o == $past(cnt_q) - TWO);
  assert_one_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == 3'd4 || mode_q == 3'd5) && out_q && cnt_en && !cfg_we && !load_we) |=> !out_o);
  assert_folded_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (mode_o <= 3'd5));

endmodule

// File: tb/tb_interval_counter_channel.sv
`timescale 1ns/1ps
module tb_interval_counter_channel;
  logic clk = 1'b0, rst_n = 1'b0, cnt_en = 1'b0, gate = 1'b1;
  logic cfg_we = 1'b0, cfg_bcd = 1'b0, load_we = 1'b0;
  logic [2:0] cfg_mode = 3'd0;
  logic [15:0] load_val = '0;
  logic [15:0] count_o;
  logic out_o, bcd_o;
  logic [2:0] mode_o;
  int n_chk = 0, n_fail = 0;

  interval_counter_channel #(.W(16)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gate(gate),
    .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd),
    .load_we(load_we), .load_val(load_val),
    .count_o(count_o), .out_o(out_o), .mode_o(mode_o), .bcd_o(bcd_o));

  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_mode(input logic [2:0] m, input logic b);
    cfg_we = 1'b1; cfg_mode = m; cfg_bcd = b;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load(input int v);
    load_we = 1'b1; load_val = 16'(v);
    @(negedge clk);
    load_we = 1'b0;
  endtask

  task automatic tick(input int n);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic gate_rise();
    gate = 1'b0;
    @(negedge clk);
    gate = 1'b1;
    @(negedge clk);
  endtask

  task automatic square(input int n);
    set_mode(3'd3, 1'b0);
    load(n);
    for (int k = 0; k <= 3 * n + 1; k++) begin
      chk("R7", "square out", int'(out_o), int'((k % n) < (n + 1) / 2));
      tick(1);
    end
  endtask

  initial begin
    #(20 * 190000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset out", int'(out_o), 0);
    chk("R1", "reset count", int'(count_o), 0);
    chk("R1", "reset mode", int'(mode_o), 0);
    load(7); tick(5);
    chk("R1", "unprogrammed out", int'(out_o), 0);
    chk("R1", "unprogrammed count", int'(count_o), 0);

    set_mode(3'd0, 1'b0); load(5);
    for (int k = 0; k <= 8; k++) begin
      chk("R3", "mode0 count", int'(count_o), (5 - k) & 16'hFFFF);
      chk("R4", "mode0 out", int'(out_o), int'(k >= 5));
      tick(1);
    end
    gate = 1'b0; tick(3);
    chk("R9", "mode0 gate low hold", int'(count_o), 16'hFFFC);
    gate_rise();
    chk("R9", "mode0 rise no restart", int'(count_o), 16'hFFFC);
    tick(1);
    chk("R9", "mode0 resume", int'(count_o), 16'hFFFB);
    load(10);
    chk("R10", "mode0 load count", int'(count_o), 10);
    chk("R4", "mode0 load out", int'(out_o), 0);
    tick(3); load(2);
    chk("R10", "mode0 reload immediate", int'(count_o), 2);
    tick(1);
    chk("R4", "mode0 not yet", int'(out_o), 0);
    tick(1);
    chk("R4", "mode0 terminal", int'(out_o), 1);

    set_mode(3'd2, 1'b0); load(4);
    for (int k = 0; k <= 12; k++) begin
      chk("R6", "mode2 out", int'(out_o), int'((k % 4 == 0) && (k != 0)));
      chk("R6", "mode2 count", int'(count_o), 4 - (k % 4));
      tick(1);
    end
    load(2);
    chk("R10", "mode2 deferred", int'(count_o), 3);
    tick(2);
    chk("R10", "mode2 old period", int'(out_o), 0);
    tick(1);
    chk("R10", "mode2 reload pulse", int'(out_o), 1);
    chk("R10", "mode2 new count", int'(count_o), 2);
    tick(1);
    chk("R6", "mode2 pulse ends", int'(out_o), 0);
    tick(1);
    chk("R10", "mode2 new period", int'(out_o), 1);

    set_mode(3'd2, 1'b0); load(5); tick(2);
    gate = 1'b0; tick(2);
    chk("R9", "mode2 gate hold", int'(count_o), 3);
    gate = 1'b1; @(negedge clk);
    chk("R9", "mode2 retrigger", int'(count_o), 5);

    square(5); square(4); square(1); square(3);
    set_mode(3'd3, 1'b0); load(4); tick(1);
    chk("R7", "square step", int'(count_o), 2);

    set_mode(3'd7, 1'b1);
    chk("R11", "fold 7", int'(mode_o), 3);
    chk("R11", "bcd flag", int'(bcd_o), 1);
    set_mode(3'd6, 1'b0);
    chk("R11", "fold 6", int'(mode_o), 2);
    load(3); tick(3);
    chk("R11", "mode6 pulse", int'(out_o), 1);

    set_mode(3'd4, 1'b0); load(3);
    for (int k = 0; k <= 6; k++) begin
      chk("R8", "mode4 out", int'(out_o), int'(k == 3));
      chk("R3", "mode4 count", int'(count_o), (3 - k) & 16'hFFFF);
      tick(1);
    end

    set_mode(3'd1, 1'b0); load(3); tick(4);
    chk("R5", "mode1 idle", int'(out_o), 0);
    gate_rise();
    chk("R5", "mode1 trigger count", int'(count_o), 3);
    for (int k = 0; k <= 5; k++) begin
      chk("R5", "mode1 out", int'(out_o), int'(k < 3));
      tick(1);
    end
    gate_rise(); tick(2);
    chk("R5", "mode1 mid", int'(count_o), 1);
    gate_rise();
    chk("R9", "mode1 retrigger", int'(count_o), 3);
    chk("R5", "mode1 retrigger out", int'(out_o), 1);
    tick(3);
    chk("R5", "mode1 end", int'(out_o), 0);
    load(6);
    chk("R10", "mode1 deferred", int'(count_o), 16'hFFFF & (0 - 0));
    gate_rise();
    chk("R10", "mode1 new count", int'(count_o), 6);

    set_mode(3'd5, 1'b0); load(2); gate_rise();
    for (int k = 0; k <= 5; k++) begin
      chk("R8", "mode5 out", int'(out_o), int'(k == 2));
      tick(1);
    end

    set_mode(3'd2, 1'b0); load(0);
    chk("R2", "zero load", int'(count_o), 0);
    tick(1);
    chk("R2", "zero first tick", int'(count_o), 16'hFFFF);
    tick(65534);
    chk("R2", "zero before end", int'(count_o), 1);
    chk("R2", "zero no pulse", int'(out_o), 0);
    tick(1);
    chk("R2", "zero pulse", int'(out_o), 1);
    chk("R2", "zero reload", int'(count_o), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule